// File: doc/BRIEF.md
# OOK Carrier Burst Transmitter

This block produces an on-off-keyed carrier for a line modem. A phase accumulator advances on every master clock cycle by a tuning word. Its top six bits address a 64-point sine waveform, which the block builds from a quarter-wave table and symmetry. An envelope level between zero and full scale multiplies the sample. The envelope climbs one step per clock while the active-low data input is held low, and falls one step per clock once the input goes high. The carrier therefore fades in and out instead of switching abruptly.

The result is a signed sample word meant for an external DAC, together with an output-enable flag. When the flag is low, the output stage is meant to float at high impedance. The flag stays high for as long as any envelope amplitude remains, so the tail of a ramp-down is always driven. Adjacent low data periods simply hold the envelope at full scale, which gives NRZ behaviour with no gap in the carrier. An active-high power-down input clears the transmit state and holds it clear, while the clock itself keeps running.

Top module: `ook_burst_tx`

## Requirements
- R1: While rst_n is low, sample_out is 0, out_en is 0, and the phase and envelope level are both cleared to 0.
- R2: On each clock edge with power_down low, the 16-bit phase accumulator adds tuning, wrapping modulo 2^16. Phase bits [15:10] form the table index.
- R3: The waveform value at index k (0..63) is round(127*sin(2*pi*k/64)) as a signed 8-bit two's-complement number. At full envelope, sample_out equals this value.
- R4: With data_n low and power_down low, the envelope level rises by 1 per clock until it reaches 16, then holds there.
- R5: With data_n high and power_down low, the envelope level falls by 1 per clock until it reaches 0. A fall in progress turns into a rise on the first clock at which data_n is low again.
- R6: sample_out equals floor(W*L/16), where W is the waveform value at the current phase index and L is the current envelope level (0..16).
- R7: out_en is 1 exactly when the envelope level is nonzero. It stays high through a ramp-down and drops in the same cycle the level reaches 0. While out_en is 0, sample_out is 0.
- R8: While data_n stays low at full level, the level remains 16 and out_en never drops, so consecutive active bits form one continuous burst.
- R9: A clock edge with power_down high sets the level and phase to 0, whatever data_n is. out_en and sample_out are then 0.
- R10: When tuning is 0, the phase holds its value and the carrier sample stays constant at a constant envelope level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock that steps the waveform |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_n | input | 1 | Transmit data, active low (low sends carrier) |
| power_down | input | 1 | Disables transmission when high |
| tuning | input | 16 | Phase increment per clock (carrier frequency) |
| sample_out | output | 8 | Signed shaped carrier sample for the DAC |
| out_en | output | 1 | Output drive enable (low means high impedance) |

## Verification
A tuning word of zero pins the phase on the quarter-wave peak. This isolates the envelope, so each ramp step appears as a distinct amplitude, and a reversal in the middle of a fall can be told apart from a restart at zero. A tuning word of 0x0400 walks one table entry per clock and checks every waveform value at full level. Long low stretches separate true NRZ joining from a burst that drops out between bits. Random run lengths of data, occasional power-down pulses and random tuning words then exercise phase wrap, partial ramps that reverse at every depth, and power-down hitting in the middle of a ramp.

// File: rtl/ook_burst_tx.sv
module ook_burst_tx #(
  parameter int PHASE_W    = 16,
  parameter int RAMP_STEPS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_n,
  input  logic                power_down,
  input  logic [PHASE_W-1:0]  tuning,
  output logic signed [7:0]   sample_out,
  output logic                out_en
);
  localparam int SAMPLE_W = 8;
  localparam int IDX_W    = 6;
  localparam int LVL_W    = $clog2(RAMP_STEPS) + 1;
  localparam int SHIFT    = $clog2(RAMP_STEPS);
  localparam int PROD_W   = SAMPLE_W + LVL_W + 1;

  logic [PHASE_W-1:0] phase_q;
  logic [LVL_W-1:0]   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (power_down) phase_q <= '0;
    else                 phase_q <= phase_q + tuning;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level_q <= '0;
    else if (power_down) level_q <= '0;
    else if (!data_n) begin
      if (level_q != LVL_W'(RAMP_STEPS)) level_q <= level_q + 1'b1;
    end else if (level_q != '0) level_q <= level_q - 1'b1;
  end

  function automatic logic [6:0] quarter(input logic [4:0] k);
    case (k)
      5'd0:  quarter = 7'd0;
      5'd1:  quarter = 7'd12;
      5'd2:  quarter = 7'd25;
      5'd3:  quarter = 7'd37;
      5'd4:  quarter = 7'd49;
      5'd5:  quarter = 7'd60;
      5'd6:  quarter = 7'd71;
      5'd7:  quarter = 7'd81;
      5'd8:  quarter = 7'd90;
      5'd9:  quarter = 7'd98;
      5'd10: quarter = 7'd106;
      5'd11: quarter = 7'd112;
      5'd12: quarter = 7'd117;
      5'd13: quarter = 7'd122;
      5'd14: quarter = 7'd125;
      5'd15: quarter = 7'd126;
      default: quarter = 7'd127;
    endcase
  endfunction

  logic [IDX_W-1:0]           idx;
  logic [4:0]                 qk;
  logic [6:0]                 mag;
  logic signed [SAMPLE_W-1:0] wave;
  logic signed [PROD_W-1:0]   prod;

  assign idx  = phase_q[PHASE_W-1 -: IDX_W];
  assign qk   = idx[4] ? (5'd16 - {1'b0, idx[3:0]}) : {1'b0, idx[3:0]};
  assign mag  = quarter(qk);
  assign wave = idx[5] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign prod = wave * $signed({1'b0, level_q});

  assign sample_out = SAMPLE_W'(prod >>> SHIFT);
  assign out_en     = (level_q != '0);
endmodule

// File: rtl/ook_burst_tx_chk.sv
module ook_burst_tx_chk #(
  parameter int PHASE_W    = 16,
  parameter int RAMP_STEPS = 16,
  parameter int LVL_W      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               data_n,
  input logic               power_down,
  input logic [PHASE_W-1:0] tuning,
  input logic signed [7:0]  sample_out,
  input logic               out_en,
  input logic [PHASE_W-1:0] phase_q,
  input logic [LVL_W-1:0]   level_q
);
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    !power_down |=> phase_q == PHASE_W'($past(phase_q) + $past(tuning)));

  a_r4_ramp_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_down && !data_n && level_q != LVL_W'(RAMP_STEPS)) |=> level_q == $past(level_q) + 1'b1);

  a_r5_ramp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_down && data_n && level_q != '0) |=> level_q == $past(level_q) - 1'b1);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> sample_out == 8'sd0);

  a_r8_nrz_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_down && !data_n && level_q == LVL_W'(RAMP_STEPS)) |=> (out_en && level_q == LVL_W'(RAMP_STEPS)));

  a_r9_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (!out_en && phase_q == '0));
endmodule

bind ook_burst_tx ook_burst_tx_chk #(
  .PHASE_W(PHASE_W), .RAMP_STEPS(RAMP_STEPS), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .data_n(data_n), .power_down(power_down),
  .tuning(tuning), .sample_out(sample_out), .out_en(out_en),
  .phase_q(phase_q), .level_q(level_q)
);

// File: tb/ook_burst_tx_tb_top.sv
`timescale 1ns/1ps
module ook_burst_tx_tb_top;
  logic clk = 0, rst_n = 0, data_n = 1, power_down = 0;
  logic [15:0] tuning = '0;
  logic signed [7:0] sample_out;
  logic out_en;

  int tests = 0, fails = 0;
  logic [15:0] m_phase = '0;
  int m_level = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ook_burst_tx dut_i (.clk(clk), .rst_n(rst_n), .data_n(data_n), .power_down(power_down),
                      .tuning(tuning), .sample_out(sample_out), .out_en(out_en));

  function automatic int sine_ref(input int k);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    return int'(v);
  endfunction

  function automatic int exp_sample(input logic [15:0] ph, input int lvl);
    int p;
    p = sine_ref(int'(ph[15:10])) * lvl;
    return p >>> 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic dn, input logic p, input logic [15:0] tw, input string tag);
    @(negedge clk);
    data_n = dn; power_down = p; tuning = tw;
    @(posedge clk);
    if (p) begin m_phase = '0; m_level = 0; end
    else begin
      m_phase = m_phase + tw;
      if (!dn) begin if (m_level < 16) m_level++; end
      else if (m_level > 0) m_level--;
    end
    #2;
    chk(p ? "R9" : tag, int'(sample_out), exp_sample(m_phase, m_level));
    chk(p ? "R9" : "R7", int'(out_en), (m_level != 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #15;
    chk("R1", int'(sample_out), 0);
    chk("R1", int'(out_en), 0);
    rst_n = 1;
    tick(1, 0, 16'h4000, "R2");
    for (int i = 0; i < 16; i++) tick(0, 0, 16'h0000, "R4");
    for (int i = 0; i < 4; i++) tick(0, 0, 16'h0000, "R10");
    chk("R10", int'(sample_out), 127);
    for (int i = 0; i < 5; i++) tick(1, 0, 16'h0000, "R5");
    chk("R5", int'(sample_out), (127 * 11) >>> 4);
    for (int i = 0; i < 3; i++) tick(0, 0, 16'h0000, "R5");
    chk("R5", int'(sample_out), (127 * 14) >>> 4);
    for (int i = 0; i < 13; i++) tick(1, 0, 16'h0000, "R5");
    chk("R7", int'(out_en), 1);
    tick(1, 0, 16'h0000, "R7");
    chk("R7", int'(out_en), 0);
    for (int i = 0; i < 16; i++) tick(0, 0, 16'h0400, "R6");
    for (int i = 0; i < 64; i++) tick(0, 0, 16'h0400, "R3");
    for (int i = 0; i < 100; i++) begin
      tick(0, 0, 16'($urandom), "R8");
      chk("R8", int'(out_en), 1);
    end
    tick(0, 1, 16'h1234, "R9");
    chk("R9", int'(out_en), 0);
    for (int seg = 0; seg < 400; seg++) begin
      logic dn, pdv;
      logic [15:0] tw;
      int len;
      dn  = 1'($urandom);
      pdv = ($urandom % 16) == 0;
      tw  = 16'($urandom);
      len = 1 + int'($urandom % 30);
      for (int j = 0; j < len; j++) tick(dn, pdv, tw, "R2");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule